// File: doc/BRIEF.md
# Cascadable Interval Timer Unit

This block is an interval timer that is read and written over a small register bus. It holds two 8-bit counting halves, A and B. One control bit decides whether the halves count on their own or act as one 16-bit counter, with B as the upper byte. All counting is paced by a single tick. The tick comes from one of several taps on a free-running system-clock prescaler, from a slow sub clock, or from an external clock pin. Both the sub clock and the external pin are brought into the system clock domain before use.

Each half has its own compare register. When a counter equals its compare value on a tick where counting is enabled, the counter returns to zero and a sticky pending flag is set. Software can poll the flag, or it can take it as an interrupt once the interrupt enable is set. A write-only strobe zeroes both halves at any moment, so that software can start an exact interval. In 8-bit mode the two halves share the control settings (source, enable, interrupt enable), but each has its own compare value and pending flag.

Top module: `interval_timer_top`

## Requirements
- R1: After reset the control register, both compare registers, both counters, both pending flags, `rdata`, `irq_a` and `irq_b` are all 0.
- R2: The control register sits at address 0. Its bits are: bit 7 interrupt enable, bits 6:4 source select, bit 3 clear strobe, bit 2 count enable, bit 1 width mode (1 = one 16-bit counter), bit 0 unused. Bits 3 and 0 always read back as 0.
- R3: A control write with bit 3 set zeroes both counters in the cycle of the write. A control write with bit 3 clear leaves the counters unchanged.
- R4: The source select codes map as follows: 0 = system clock/512, 1 = /256, 2 = /64, 3 = /8, 4 = undivided system clock, 5 = sub clock, 6 = external pin. Code 7 never advances the counters.
- R5: While bit 2 is 0, neither counter advances.
- R6: In 8-bit mode, A (count readable at address 4, compare at address 1) and B (count at address 5, compare at address 2) each count one step per tick. On a tick where a half equals its compare value, that half returns to 0 and sets its pending flag: bit 0 for A and bit 1 for B of the pending register at address 3.
- R7: In 16-bit mode, {B,A} counts as one value with carry from A into B. It is compared with {compare B, compare A}. A match zeroes both halves and sets only pending bit 0.
- R8: A pending flag is set on a match whether or not interrupts are enabled. It is cleared only by writing 0 to its bit at address 3. Writing 1 there has no effect.
- R9: `irq_a` equals (interrupt enable AND pending bit 0), registered one cycle. `irq_b` equals (interrupt enable AND pending bit 1 AND 8-bit mode), also registered one cycle.
- R10: When a clear write and a match fall in the same cycle, the counters end at 0 and the pending flag is still set.
- R11: The sub clock and external pin inputs pass through a two-flop synchronizer. Each rising edge gives exactly one count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` updates at the next edge |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sub_clk | input | 1 | Asynchronous sub clock |
| ext_clk | input | 1 | Asynchronous external count clock |
| irq_a | output | 1 | Interrupt for half A / 16-bit counter |
| irq_b | output | 1 | Interrupt for half B (8-bit mode only) |

## Verification
The hardest case to reach from the ports is a clear write that lands in exactly the cycle where a match occurs. The bench selects the undivided system clock so that a tick occurs on every edge. It starts counting with a write on a known edge, then issues a clear-and-stop write precisely five idle cycles later, the cycle in which A equals its compare value. The 16-bit carry path is reached by stepping the external pin 259 times, and the /8 tap is checked by enabling counting for exactly 80 edges.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 3;

  localparam int unsigned CTL_IE   = 7;
  localparam int unsigned CTL_SEL  = 4;
  localparam int unsigned CTL_CLR  = 3;
  localparam int unsigned CTL_EN   = 2;
  localparam int unsigned CTL_MODE = 1;
  localparam logic [BUS_W-1:0] CTL_KEEP_MASK = 8'hF6;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL  = 3'd0,
    ADDR_CMP_A = 3'd1,
    ADDR_CMP_B = 3'd2,
    ADDR_PEND  = 3'd3,
    ADDR_CNT_A = 3'd4,
    ADDR_CNT_B = 3'd5
  } reg_addr_e;

  typedef enum logic [2:0] {
    SRC_DIV512 = 3'd0,
    SRC_DIV256 = 3'd1,
    SRC_DIV64  = 3'd2,
    SRC_DIV8   = 3'd3,
    SRC_SYS    = 3'd4,
    SRC_SUB    = 3'd5,
    SRC_EXT    = 3'd6,
    SRC_NONE   = 3'd7
  } clk_src_e;
endpackage

// File: rtl/itimer_edge_sync.sv
module itimer_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/itimer_tick_gen.sv
module itimer_tick_gen
  import itimer_pkg::*;
#(
  parameter int unsigned PRE_W       = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       sub_clk,
  input  logic       ext_clk,
  output logic       tick
);
  localparam int unsigned TAP_512 = 9;
  localparam int unsigned TAP_256 = 8;
  localparam int unsigned TAP_64  = 6;
  localparam int unsigned TAP_8   = 3;
  localparam int unsigned N_ASYNC = 2;

  logic [PRE_W-1:0]   div_q;
  logic [N_ASYNC-1:0] async_src;
  logic [N_ASYNC-1:0] async_rise;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign async_src = {ext_clk, sub_clk};

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    itimer_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (async_src[g]),
      .rise     (async_rise[g])
    );
  end

  always_comb begin
    case (clk_src_e'(sel))
      SRC_DIV512: tick = &div_q[TAP_512-1:0];
      SRC_DIV256: tick = &div_q[TAP_256-1:0];
      SRC_DIV64:  tick = &div_q[TAP_64-1:0];
      SRC_DIV8:   tick = &div_q[TAP_8-1:0];
      SRC_SYS:    tick = 1'b1;
      SRC_SUB:    tick = async_rise[0];
      SRC_EXT:    tick = async_rise[1];
      default:    tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/itimer_count_core.sv
module itimer_count_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             wide_mode,
  input  logic             clr,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic             hit_a,
  output logic             hit_b
);
  localparam int unsigned WIDE_W = 2 * CNT_W;

  logic              adv;
  logic [WIDE_W-1:0] wide_cnt;
  logic [WIDE_W-1:0] wide_cmp;
  logic              hit_wide;
  logic              hit_lo;
  logic              hit_hi;
  logic [WIDE_W-1:0] wide_nx;

  assign adv      = tick & en;
  assign wide_cnt = {cnt_b, cnt_a};
  assign wide_cmp = {cmp_b, cmp_a};
  assign hit_wide = adv & wide_mode & (wide_cnt == wide_cmp);
  assign hit_lo   = adv & ~wide_mode & (cnt_a == cmp_a);
  assign hit_hi   = adv & ~wide_mode & (cnt_b == cmp_b);
  assign hit_a    = hit_wide | hit_lo;
  assign hit_b    = hit_hi;

  always_comb begin
    wide_nx = wide_cnt;
    if (clr) begin
      wide_nx = '0;
    end else if (adv) begin
      if (wide_mode) begin
        wide_nx = hit_wide ? '0 : wide_cnt + 1'b1;
      end else begin
        wide_nx[CNT_W-1:0]      = hit_lo ? '0 : cnt_a + 1'b1;
        wide_nx[WIDE_W-1:CNT_W] = hit_hi ? '0 : cnt_b + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else begin
      cnt_a <= wide_nx[CNT_W-1:0];
      cnt_b <= wide_nx[WIDE_W-1:CNT_W];
    end
  end
endmodule

// File: rtl/interval_timer_top.sv
module interval_timer_top
  import itimer_pkg::*;
#(
  parameter int unsigned PRE_W       = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              sub_clk,
  input  logic              ext_clk,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int unsigned CNT_W = BUS_W;

  logic [BUS_W-1:0] ctrl_q;
  logic [CNT_W-1:0] cmp_a_q, cmp_b_q;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic [1:0]       pend_q, pend_nx;
  logic             hit_a, hit_b;
  logic             tick;
  logic             clr_req;
  logic             wr_ctrl, wr_pend;

  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign wr_pend = wr_en && (addr == ADDR_PEND);
  assign clr_req = wr_ctrl && wdata[CTL_CLR];

  itimer_tick_gen #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .sel     (ctrl_q[CTL_SEL +: 3]),
    .sub_clk (sub_clk),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  itimer_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .en        (ctrl_q[CTL_EN]),
    .wide_mode (ctrl_q[CTL_MODE]),
    .clr       (clr_req),
    .cmp_a     (cmp_a_q),
    .cmp_b     (cmp_b_q),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .hit_a     (hit_a),
    .hit_b     (hit_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        ADDR_CTRL:  ctrl_q  <= wdata & CTL_KEEP_MASK;
        ADDR_CMP_A: cmp_a_q <= wdata;
        ADDR_CMP_B: cmp_b_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    pend_nx = pend_q;
    if (wr_pend) pend_nx = pend_q & wdata[1:0];
    pend_nx = pend_nx | {hit_b, hit_a};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_a  <= 1'b0;
      irq_b  <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      irq_a  <= ctrl_q[CTL_IE] & pend_q[0];
      irq_b  <= ctrl_q[CTL_IE] & pend_q[1] & ~ctrl_q[CTL_MODE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (reg_addr_e'(addr))
        ADDR_CTRL:  rdata <= ctrl_q;
        ADDR_CMP_A: rdata <= cmp_a_q;
        ADDR_CMP_B: rdata <= cmp_b_q;
        ADDR_PEND:  rdata <= {{(BUS_W-2){1'b0}}, pend_q};
        ADDR_CNT_A: rdata <= cnt_a;
        ADDR_CNT_B: rdata <= cnt_b;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/itimer_checker.sv
module itimer_checker
  import itimer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  ctrl_q,
  input logic [CNT_W-1:0]  cnt_a,
  input logic [CNT_W-1:0]  cnt_b,
  input logic [1:0]        pend_q,
  input logic              irq_a,
  input logic              irq_b
);
  logic clr_wr, pend_wr;
  assign clr_wr  = wr_en && (addr == ADDR_CTRL) && wdata[CTL_CLR];
  assign pend_wr = wr_en && (addr == ADDR_PEND);

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> (cnt_a == '0) && (cnt_b == '0));

  assert_unused_src_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTL_SEL +: 3] == 3'b111 && !clr_wr) |=> $stable(cnt_a) && $stable(cnt_b));

  assert_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTL_EN] && !clr_wr) |=> $stable(cnt_a) && $stable(cnt_b));

  assert_wide_no_b_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTL_MODE] && !pend_q[1]) |=> !pend_q[1]);

  assert_sticky_a_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q[0] && !(pend_wr && !wdata[0])) |=> pend_q[0]);

  assert_sticky_b_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q[1] && !(pend_wr && !wdata[1])) |=> pend_q[1]);

  assert_irq_a_src_R9: assert property (@(posedge clk) disable iff (rst)
    irq_a |-> $past(ctrl_q[CTL_IE] && pend_q[0]));

  assert_irq_b_src_R9: assert property (@(posedge clk) disable iff (rst)
    irq_b |-> $past(ctrl_q[CTL_IE] && pend_q[1] && !ctrl_q[CTL_MODE]));
endmodule

bind interval_timer_top itimer_checker #(.CNT_W(CNT_W)) u_itimer_checker (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .ctrl_q (ctrl_q),
  .cnt_a  (cnt_a),
  .cnt_b  (cnt_b),
  .pend_q (pend_q),
  .irq_a  (irq_a),
  .irq_b  (irq_b)
);

// File: tb/test_interval_timer_top.sv
module test_interval_timer_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sub_clk = 1'b0;
  logic       ext_clk = 1'b0;
  logic       irq_a, irq_b;

  int compared = 0;
  int mismatched = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer_top i_interval_timer_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sub_clk(sub_clk), .ext_clk(ext_clk),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compares each registered read result with the scoreboard head
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (rdata !== e) begin
        mismatched++;
        $display("FAIL %s: got %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    compared++;
    if (act !== e) begin
      mismatched++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic pulse(input bit use_sub, input int n);
    for (int i = 0; i < n; i++) begin
      if (use_sub) sub_clk = 1'b1; else ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      sub_clk = 1'b0; ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, 8'h00, "R1 ctrl");
    rd(3'd3, 8'h00, "R1 pend");
    rd(3'd4, 8'h00, "R1 cntA");
    rd(3'd2, 8'h00, "R1 cmpB");
    chk(irq_a, 1'b0, "R1 irq_a");
    chk(irq_b, 1'b0, "R1 irq_b");

    // R4 code 7 never counts; R2 readback
    wr(3'd0, 8'h74);
    rd(3'd0, 8'h74, "R2 ctrl readback");
    pulse(0, 3);
    rd(3'd4, 8'h00, "R4 code 7 no advance");

    // R5 enable off
    wr(3'd0, 8'h60);
    pulse(0, 2);
    rd(3'd4, 8'h00, "R5 disabled no advance");

    // R6 8-bit halves with external pin (R11)
    wr(3'd1, 8'd3);
    wr(3'd2, 8'd5);
    wr(3'd0, 8'h64);
    pulse(0, 3);
    rd(3'd4, 8'd3, "R11 cntA after 3 edges");
    rd(3'd3, 8'h00, "R6 no match yet");
    pulse(0, 1);
    rd(3'd4, 8'd0, "R6 A wraps on match");
    rd(3'd5, 8'd4, "R6 B independent");
    rd(3'd3, 8'h01, "R6 A pending");
    pulse(0, 2);
    rd(3'd5, 8'd0, "R6 B wraps on match");
    rd(3'd4, 8'd2, "R6 A after 6");
    rd(3'd3, 8'h03, "R6 both pending");
    chk(irq_a, 1'b0, "R8 polled, irq_a off");

    // R9 interrupt enable
    wr(3'd0, 8'hE4);
    @(negedge clk);
    chk(irq_a, 1'b1, "R9 irq_a on");
    chk(irq_b, 1'b1, "R9 irq_b on");

    // R8 clear by writing 0, ones have no effect
    wr(3'd3, 8'h02);
    rd(3'd3, 8'h02, "R8 clear bit0 only");
    @(negedge clk);
    chk(irq_a, 1'b0, "R9 irq_a follows pend");
    wr(3'd3, 8'h03);
    rd(3'd3, 8'h02, "R8 write 1 no effect");
    wr(3'd3, 8'h00);
    rd(3'd3, 8'h00, "R8 all cleared");

    // R3 clear strobe
    wr(3'd0, 8'hE4);
    rd(3'd4, 8'd2, "R3 bit3=0 no effect");
    wr(3'd0, 8'hEC);
    rd(3'd4, 8'd0, "R3 cntA cleared");
    rd(3'd0, 8'hE4, "R2 clear reads 0");

    // R11 sub clock source
    wr(3'd0, 8'h54);
    pulse(1, 2);
    rd(3'd4, 8'd2, "R11 sub clock counts");
    pulse(0, 1);
    rd(3'd5, 8'd2, "R4 ext ignored when sub selected");

    // R7 16-bit mode
    wr(3'd1, 8'd2);
    wr(3'd2, 8'd1);
    wr(3'd0, 8'h6E);
    pulse(0, 255);
    rd(3'd4, 8'hFF, "R7 low byte full");
    rd(3'd5, 8'h00, "R7 high byte zero");
    pulse(0, 1);
    rd(3'd4, 8'h00, "R7 low after carry");
    rd(3'd5, 8'h01, "R7 carry into B");
    pulse(0, 2);
    rd(3'd3, 8'h00, "R7 no match at 0102 yet");
    pulse(0, 1);
    rd(3'd4, 8'h00, "R7 wide wrap A");
    rd(3'd5, 8'h00, "R7 wide wrap B");
    rd(3'd3, 8'h01, "R7 only bit0 pending");
    wr(3'd3, 8'h00);

    // R4 divide-by-8 for exactly 80 edges
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h38);
    wr(3'd0, 8'h34);
    repeat (79) @(negedge clk);
    wr(3'd0, 8'h30);
    rd(3'd4, 8'd10, "R4 div8 ticks");
    rd(3'd5, 8'd10, "R4 div8 ticks B");

    // R10 clear in the match cycle
    wr(3'd1, 8'd5);
    wr(3'd2, 8'd200);
    wr(3'd0, 8'h48);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h44);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h48);
    rd(3'd4, 8'd0, "R10 cntA zero");
    rd(3'd5, 8'd0, "R10 clear wins on B");
    rd(3'd3, 8'h01, "R10 pending still set");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule